// File: doc/BRIEF.md
# 64-bit Prescaled Alarm Timer

The block is a free-running 64-bit time base behind a 32-bit register port. A programmable prescaler divides the block clock into ticks. On each tick the counter moves one step up or down. Software never reads the live count directly. A write to a trigger word latches the count into a snapshot pair, and a write to a second trigger word forces the counter to a preloaded 64-bit value.

A 64-bit comparator watches the counter. When the comparator is armed and the count matches, an alarm event occurs. The event disarms the comparator, optionally reloads the counter, sets a sticky status flag, and drives a held level interrupt, a one-cycle pulse, or both. The status flag is masked by an interrupt enable and is cleared by writing 1.

Top module: `prescaled_alarm_timer`

## Requirements
- R1: After reset every register reads zero. The counter is stopped, the direction is down, nothing is armed, and both interrupt outputs are low.
- R2: Writing any value to the reload trigger (byte offset 0x20) loads the counter from the 64-bit load pair (0x18 low, 0x1C high) at that clock edge, whether or not counting is enabled. While the run bit is 0 the count holds.
- R3: Writing any value to the snapshot trigger (0x0C) latches the current count into the snapshot pair (0x04 low, 0x08 high). Those words keep the latched value when the counter later changes.
- R4: Control word at 0x00: bit 31 run, bit 30 direction (1 up, 0 down), bits 28:13 divider. While running with divider n (2 to 65535), the counter moves one step every n clocks. Any control write restarts the prescaler.
- R5: A divider field of 0 gives one tick per 65536 clocks. A field of 1 gives one tick per 2 clocks.
- R6: With control bit 10 (arm) set and the count equal to the alarm pair (0x10 low, 0x14 high), an alarm event occurs. The event clears bit 10 in hardware, and this clear takes priority over a software write in the same cycle. The event also sets raw status (bit 1 of 0x28).
- R7: When control bit 29 (auto-reload) is set, an alarm event loads the counter from the load pair. When bit 29 is clear, the count is not disturbed.
- R8: The level output equals raw status AND enable (bit 0 of 0x24) AND control bit 11. It stays high until a 1 is written to bit 0 of 0x2C. Writing 0 there does nothing. Bit 0 of 0x28 reads raw status AND enable.
- R9: When control bit 12 is set and the interrupt enable is on, each alarm event gives exactly one single-cycle pulse on the edge output, one clock after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_level | output | 1 | Held alarm interrupt |
| irq_edge | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The bench counts ticks over exact edge windows, both up and down. An off-by-one in the prescaler limit, or a missed restart, would shift these results by a tick. A divider field of 0 is run for a full 65536-clock period, and a field of 1 is run at two clocks per tick. A design that took either field literally would stall or count every clock. Alarms are fired on a stopped counter so the result is deterministic. The bench checks that:
- a reload, if wrongly applied, shows up in the snapshot;
- the arm bit reads back as cleared after an event;
- a clear write with bit 0 low leaves the level output high;
- an interrupt enable of 0 masks the level output;
- the edge output is high for exactly one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 32;
  localparam int DIV_W = 16;
  localparam int CNT_W = 64;
  localparam int ADR_W = 6;

  typedef struct packed {
    logic             run;
    logic             count_up;
    logic             auto_rld;
    logic [DIV_W-1:0] divider;
    logic             edge_en;
    logic             level_en;
    logic             arm;
    logic [9:0]       spare;
  } ctrl_t;

  localparam logic [ADR_W-1:0] OFF_CTRL    = 6'h00;
  localparam logic [ADR_W-1:0] OFF_SNAP_LO = 6'h04;
  localparam logic [ADR_W-1:0] OFF_SNAP_HI = 6'h08;
  localparam logic [ADR_W-1:0] OFF_SNAP_GO = 6'h0C;
  localparam logic [ADR_W-1:0] OFF_ALM_LO  = 6'h10;
  localparam logic [ADR_W-1:0] OFF_ALM_HI  = 6'h14;
  localparam logic [ADR_W-1:0] OFF_LD_LO   = 6'h18;
  localparam logic [ADR_W-1:0] OFF_LD_HI   = 6'h1C;
  localparam logic [ADR_W-1:0] OFF_LD_GO   = 6'h20;
  localparam logic [ADR_W-1:0] OFF_IEN     = 6'h24;
  localparam logic [ADR_W-1:0] OFF_STAT    = 6'h28;
  localparam logic [ADR_W-1:0] OFF_CLR     = 6'h2C;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_field,
  output logic             tick
);
  localparam int PW = DIV_W + 1;

  // Effective clocks per tick: 0 means 2**DIV_W, 1 is raised to 2.
  function automatic logic [PW-1:0] eff_period(input logic [DIV_W-1:0] f);
    if (f == '0)      return PW'(1) << DIV_W;
    else if (f == 1)  return PW'(2);
    else              return {1'b0, f};
  endfunction

  logic [PW-1:0] phase;
  logic [PW-1:0] last_phase;

  assign last_phase = eff_period(div_field) - PW'(1);
  assign tick       = run && (phase >= last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase <= '0;
    else if (restart)   phase <= '0;
    else if (run)       phase <= tick ? '0 : phase + PW'(1);
  end

  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> phase == '0); // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             count_up,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic up);
    return up ? v + CNT_W'(1) : v - CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load_now) count <= load_val;
    else if (tick)     count <= step(count, count_up);
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> count == $past(load_val)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_now && !tick) |=> $stable(count)); // R2
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_now && tick) |=>
      count == ($past(count_up) ? $past(count) + CNT_W'(1) : $past(count) - CNT_W'(1))); // R4
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] target,
  input  logic             level_en,
  input  logic             edge_en,
  input  logic             irq_on,
  input  logic             clear,
  output logic             hit,
  output logic             raw_flag,
  output logic             irq_level,
  output logic             irq_edge
);
  assign hit = armed && (count == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_flag <= 1'b0;
      irq_edge <= 1'b0;
    end else begin
      if (hit)        raw_flag <= 1'b1;
      else if (clear) raw_flag <= 1'b0;
      irq_edge <= hit && edge_en && irq_on;
    end
  end

  assign irq_level = raw_flag && irq_on && level_en;

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw_flag); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !hit) |=> !raw_flag); // R8
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |=> !irq_edge); // R9
endmodule

// File: rtl/prescaled_alarm_timer.sv
module prescaled_alarm_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_level,
  output logic              irq_edge
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] alarm_val, load_val, snap_val, count;
  logic             irq_on;
  logic             wr_ctrl, wr_snap, wr_reload, wr_clr;
  logic             tick, hit, raw_flag, load_now;

  assign wr_ctrl   = bus_we && (bus_addr == OFF_CTRL);
  assign wr_snap   = bus_we && (bus_addr == OFF_SNAP_GO);
  assign wr_reload = bus_we && (bus_addr == OFF_LD_GO);
  assign wr_clr    = bus_we && (bus_addr == OFF_CLR) && bus_wdata[0];
  assign load_now  = wr_reload || (hit && ctrl.auto_rld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      alarm_val <= '0;
      load_val  <= '0;
      snap_val  <= '0;
      irq_on    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
      if (hit)     ctrl.arm <= 1'b0;
      if (bus_we) begin
        case (bus_addr)
          OFF_ALM_LO: alarm_val[31:0]  <= bus_wdata;
          OFF_ALM_HI: alarm_val[63:32] <= bus_wdata;
          OFF_LD_LO:  load_val[31:0]   <= bus_wdata;
          OFF_LD_HI:  load_val[63:32]  <= bus_wdata;
          OFF_IEN:    irq_on           <= bus_wdata[0];
          default: ;
        endcase
      end
      if (wr_snap) snap_val <= count;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL:    bus_rdata = REG_W'(ctrl);
      OFF_SNAP_LO: bus_rdata = snap_val[31:0];
      OFF_SNAP_HI: bus_rdata = snap_val[63:32];
      OFF_ALM_LO:  bus_rdata = alarm_val[31:0];
      OFF_ALM_HI:  bus_rdata = alarm_val[63:32];
      OFF_LD_LO:   bus_rdata = load_val[31:0];
      OFF_LD_HI:   bus_rdata = load_val[63:32];
      OFF_IEN:     bus_rdata = {31'b0, irq_on};
      OFF_STAT:    bus_rdata = {30'b0, raw_flag, raw_flag && irq_on};
      default:     bus_rdata = '0;
    endcase
  end

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(wr_ctrl),
    .div_field(ctrl.divider), .tick(tick));

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_up(ctrl.count_up),
    .load_now(load_now), .load_val(load_val), .count(count));

  tmr_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .armed(ctrl.arm), .count(count), .target(alarm_val),
    .level_en(ctrl.level_en), .edge_en(ctrl.edge_en), .irq_on(irq_on), .clear(wr_clr),
    .hit(hit), .raw_flag(raw_flag), .irq_level(irq_level), .irq_edge(irq_edge));

  AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !ctrl.arm); // R6
  AST_SNAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_snap |=> snap_val == $past(count)); // R3
endmodule

// File: tb/prescaled_alarm_timer_test.sv
module prescaled_alarm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_level, irq_edge;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  localparam logic [31:0] RUN = 32'h8000_0000, UP = 32'h4000_0000, ARL = 32'h2000_0000;
  localparam logic [31:0] EDG = 32'h0000_1000, LVL = 32'h0000_0800, ARM = 32'h0000_0400;
  function automatic logic [31:0] dv(input int n); return 32'(n & 16'hFFFF) << 13; endfunction

  always #2.5 clk = ~clk;

  prescaled_alarm_timer uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_edge(irq_edge));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_snap(output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(6'h0C, 32'h0);
    rd(6'h04, lo); rd(6'h08, hi);
    v = {hi, lo};
  endtask

  task automatic set_count(input logic [63:0] v);
    wr(6'h18, v[31:0]); wr(6'h1C, v[63:32]); wr(6'h20, 32'h0);
  endtask

  // Run for exactly `edges` enabled clock edges, then stop.
  task automatic run_for(input logic [31:0] cfg, input int edges);
    wr(6'h00, cfg);
    repeat (edges - 1) @(posedge clk);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 48; a += 4) begin
      rd(6'(a), d); chk("R1 reg after reset", 64'(d), 64'h0);
    end
    chk("R1 irq_level", 64'(irq_level), 0);
    chk("R1 irq_edge", 64'(irq_edge), 0);
  endtask

  task automatic t_reload_snapshot;
    logic [63:0] v;
    set_count(64'h1234_5678_9ABC_DEF0);
    repeat (10) @(posedge clk);
    rd_snap(v); chk("R2 reload while stopped, count holds", v, 64'h1234_5678_9ABC_DEF0);
    set_count(64'h0000_0000_0000_0042);
    begin
      logic [31:0] lo, hi;
      rd(6'h04, lo); rd(6'h08, hi);
      chk("R3 snapshot keeps latched value", {hi, lo}, 64'h1234_5678_9ABC_DEF0);
    end
    rd_snap(v); chk("R3 new snapshot", v, 64'h42);
  endtask

  task automatic t_count;
    logic [63:0] v;
    set_count(64'd0);
    run_for(RUN | UP | dv(4), 40);
    rd_snap(v); chk("R4 up div 4 over 40 clocks", v, 64'd10);
    set_count(64'd100);
    run_for(RUN | dv(3), 30);
    rd_snap(v); chk("R4 down div 3 over 30 clocks", v, 64'd90);
    set_count(64'd0);
    run_for(RUN | dv(3), 6);
    rd_snap(v); chk("R4 down wraps below zero", v, 64'hFFFF_FFFF_FFFF_FFFE);
    set_count(64'd0);
    run_for(RUN | UP | dv(1), 10);
    rd_snap(v); chk("R5 field 1 acts as 2", v, 64'd5);
    set_count(64'd0);
    run_for(RUN | UP | dv(0), 65535);
    rd_snap(v); chk("R5 field 0 no tick before 65536", v, 64'd0);
    set_count(64'd0);
    run_for(RUN | UP | dv(0), 65536);
    rd_snap(v); chk("R5 field 0 tick at 65536", v, 64'd1);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(6'h24, 32'h1);
    wr(6'h10, 32'd5); wr(6'h14, 32'd0);
    set_count(64'd0);
    wr(6'h00, RUN | UP | dv(2) | LVL | ARM);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R8 level high after alarm", 64'(irq_level), 1);
    rd(6'h00, d); chk("R6 arm self-cleared", 64'(d[10]), 0);
    rd(6'h28, d); chk("R6 status raw and masked", 64'(d[1:0]), 64'd3);
    wr(6'h2C, 32'h0); @(negedge clk);
    chk("R8 clear with bit0 low ignored", 64'(irq_level), 1);
    wr(6'h24, 32'h0); @(negedge clk);
    chk("R8 enable off masks level", 64'(irq_level), 0);
    rd(6'h28, d); chk("R8 masked status bit", 64'(d[1:0]), 64'd2);
    wr(6'h24, 32'h1); @(negedge clk);
    chk("R8 enable on restores level", 64'(irq_level), 1);
    wr(6'h2C, 32'h1); @(negedge clk);
    chk("R8 w1c clears level", 64'(irq_level), 0);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_reload_on_alarm;
    logic [63:0] v;
    set_count(64'd7);
    wr(6'h18, 32'd2);
    wr(6'h10, 32'd7);
    wr(6'h00, ARL | ARM);
    repeat (3) @(posedge clk);
    rd_snap(v); chk("R7 auto-reload on alarm", v, 64'd2);
    wr(6'h2C, 32'h1);
    set_count(64'd7);
    wr(6'h18, 32'd9);
    wr(6'h00, ARM);
    repeat (3) @(posedge clk);
    rd_snap(v); chk("R7 no reload when bit clear", v, 64'd7);
    wr(6'h2C, 32'h1);
  endtask

  task automatic t_edge;
    int highs = 0;
    logic [31:0] d;
    wr(6'h24, 32'h1);
    set_count(64'd7);
    wr(6'h10, 32'd7);
    wr(6'h00, EDG | ARM);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); if (irq_edge) highs++;
    end
    chk("R9 edge pulse count", 64'(highs), 64'd1);
    chk("R9 level stays low without level enable", 64'(irq_level), 0);
    rd(6'h28, d); chk("R6 edge alarm sets status", 64'(d[1]), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_reload_snapshot();
    t_count();
    t_level();
    t_reload_on_alarm();
    t_edge();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule